// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves data for one DMA channel. Software-side logic writes a control word together with a source address, a destination address and a cycle count. When the written control word has its enable bit set, the engine copies data. Each beat reads one item from the source address and then writes the same item to the destination address. A cycle is one beat, or four beats when burst mode is on. After each beat, both addresses move by their own step codes.

The memory side is a single master port that has one request channel and one response channel. The request channel is valid/ready. Once the engine raises `mem_req_valid_o`, it keeps the request and every request field stable until the slave accepts it with `mem_req_ready_i`. The slave may hold ready low for any number of cycles. The response channel has no back-pressure: the engine always accepts a response. At most one request is outstanding at any time. The engine waits for the response to a read before it issues the write for that beat.

The readback word `ctrl_o` returns the stored control fields with live status in place of three bits. Bit 0 shows that the channel is running, bit 1 shows that the transfer finished, and bit 4 shows that a bus error occurred. `remain_o` shows the live number of cycles still to run.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `ctrl_o` and `remain_o` are zero and no memory request is valid.
- R2: Each beat issues a read of the source address (`mem_req_write_o`=0), waits for its response, then issues a write of the returned data to the destination address (`mem_req_write_o`=1). Only one request is outstanding at a time, and a request stays stable while `mem_req_ready_i` is low.
- R3: Step codes are held in control bits 10:8 for the source and bits 14:12 for the destination. In single mode, code 000 leaves the address unchanged, and codes 001, 010 and 011 add 1, 2 and 4 after each beat.
- R4: In single mode, codes 101, 110 and 111 subtract 1, 2 and 4 after each beat.
- R5: Code 100 is reserved and leaves the address unchanged, in both modes.
- R6: Control bit 3 selects burst mode. In burst mode each cycle is four beats, and every nonzero step size is multiplied by four (4, 8 or 16).
- R7: Control bits 21:20 set the item size driven on `mem_req_size_o` as log2 of the byte count. 00 (word) gives 2, 01 (halfword) gives 1, 10 (byte) gives 0, and reserved 11 is treated as word (2).
- R8: `remain_o` loads the 24-bit cycle count when the control word is written. It decreases by one after the write response of the last beat of each cycle, and it can be read at any time.
- R9: When the count reaches zero, finish status (bit 1) is set, enable (bit 0) clears, and no further request is issued.
- R10: Writing a control word with bit 0 set and a cycle count of zero sets finish status on the next clock edge, with no memory access.
- R11: A response with `mem_rsp_err_i` set sets error status (bit 4), clears enable and stops the transfer, and it leaves `remain_o` unchanged. If this happens on the final beat, error takes priority and finish stays clear.
- R12: A control write while enabled is ignored. A control write while idle clears both status bits. If bit 0 is clear in that write, the engine loads the settings without starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Write strobe for control word, addresses and count |
| ctrl_i | input | 32 | Control word to write |
| src_addr_i | input | AW | Start source address |
| dst_addr_i | input | AW | Start destination address |
| cycles_i | input | CNT_W | Cycle count |
| ctrl_o | output | 32 | Stored control with live enable/finish/error bits |
| remain_o | output | CNT_W | Live remaining cycle count |
| mem_req_valid_o | output | 1 | Request valid |
| mem_req_ready_i | input | 1 | Request accepted by slave |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | AW | Request byte address |
| mem_req_size_o | output | 2 | log2 of item bytes |
| mem_req_wdata_o | output | DW | Write data |
| mem_rsp_valid_i | input | 1 | Response valid (always accepted) |
| mem_rsp_rdata_i | input | DW | Read data |
| mem_rsp_err_i | input | 1 | Response carries a bus error |

## Verification
Completion and a bus error can land in the same cycle. This happens when the write response of the last beat of the last cycle carries an error. The bench provokes it by injecting the error on exactly that access. The outcome is judged correct if error status is set, finish status stays clear, enable drops and `remain_o` still reads one. A second collision is a control write that arrives while the channel is running. The bench issues one under back-pressure and checks that both the access log and the readback fields still match the first transfer.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } seq_state_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FIN_BIT   = 1;
  localparam int CTRL_BURST_BIT = 3;
  localparam int CTRL_ERR_BIT   = 4;
  localparam int SRC_STEP_LSB   = 8;
  localparam int DST_STEP_LSB   = 12;
  localparam int WIDTH_LSB      = 20;

  // width field to log2 byte count; reserved code falls back to word
  function automatic logic [1:0] width_to_size(input logic [1:0] fld);
    case (fld)
      2'b01:   return 2'd1;
      2'b10:   return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW          = 32,
  parameter int BURST_SHIFT = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    code_i,
  input  logic          burst_i,
  output logic [AW-1:0] addr_next_o
);

  logic [AW-1:0] mag;

  always_comb begin
    case (code_i[1:0])
      2'd0:    mag = '0;
      2'd1:    mag = AW'(1);
      2'd2:    mag = AW'(2);
      default: mag = AW'(4);
    endcase
    if (burst_i) mag = mag << BURST_SHIFT;
    addr_next_o = code_i[2] ? (addr_i - mag) : (addr_i + mag);
  end

endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq
  import dma_chan_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int BURST_BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             burst_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_err_i,
  output logic             busy_o,
  output logic             req_valid_o,
  output logic             req_write_o,
  output logic             capture_o,
  output logic             advance_o,
  output logic             finish_o,
  output logic             fault_o,
  output logic [CNT_W-1:0] remain_o
);

  localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

  seq_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] beat_q;
  logic              last_beat;
  logic              waiting;

  assign last_beat   = !burst_i || (beat_q == LAST_BEAT);
  assign waiting     = (st_q == ST_RD_WAIT) || (st_q == ST_WR_WAIT);
  assign busy_o      = (st_q != ST_IDLE);
  assign req_valid_o = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
  assign req_write_o = (st_q == ST_WR_REQ);
  assign capture_o   = (st_q == ST_RD_WAIT) && rsp_valid_i && !rsp_err_i;
  assign advance_o   = (st_q == ST_WR_WAIT) && rsp_valid_i && !rsp_err_i;
  assign finish_o    = advance_o && last_beat && (cnt_q == CNT_W'(1));
  assign fault_o     = waiting && rsp_valid_i && rsp_err_i;
  assign remain_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load_i) begin
            cnt_q  <= cycles_i;
            beat_q <= '0;
            st_q   <= go_i ? ST_RD_REQ : ST_IDLE;
          end
        end
        ST_RD_REQ:  if (req_ready_i) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (rsp_valid_i) st_q <= rsp_err_i ? ST_IDLE : ST_WR_REQ;
        end
        ST_WR_REQ:  if (req_ready_i) st_q <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_err_i) begin
              st_q <= ST_IDLE;
            end else if (last_beat) begin
              beat_q <= '0;
              cnt_q  <= cnt_q - CNT_W'(1);
              st_q   <= (cnt_q == CNT_W'(1)) ? ST_IDLE : ST_RD_REQ;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
              st_q   <= ST_RD_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CNT_W       = 24,
  parameter int BURST_BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [31:0]      ctrl_i,
  input  logic [AW-1:0]    src_addr_i,
  input  logic [AW-1:0]    dst_addr_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic [31:0]      ctrl_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_write_o,
  output logic [AW-1:0]    mem_req_addr_o,
  output logic [1:0]       mem_req_size_o,
  output logic [DW-1:0]    mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [DW-1:0]    mem_rsp_rdata_i,
  input  logic             mem_rsp_err_i
);

  localparam int BURST_SHIFT = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 0;
  localparam int N_SIDES     = 2;

  logic [31:0]   ctrl_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] data_q;
  logic          fin_q, err_q;

  logic busy, accept, capture, advance, finish, fault;
  logic [AW-1:0] cur_addr [N_SIDES];
  logic [AW-1:0] nxt_addr [N_SIDES];

  assign accept      = ctrl_wr_i && !busy;
  assign cur_addr[0] = src_q;
  assign cur_addr[1] = dst_q;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    localparam int CODE_LSB = (s == 0) ? SRC_STEP_LSB : DST_STEP_LSB;
    dma_addr_step #(
      .AW          (AW),
      .BURST_SHIFT (BURST_SHIFT)
    ) u_step (
      .addr_i      (cur_addr[s]),
      .code_i      (ctrl_q[CODE_LSB +: 3]),
      .burst_i     (ctrl_q[CTRL_BURST_BIT]),
      .addr_next_o (nxt_addr[s])
    );
  end

  dma_beat_seq #(
    .CNT_W       (CNT_W),
    .BURST_BEATS (BURST_BEATS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .go_i        (ctrl_i[CTRL_EN_BIT] && (cycles_i != '0)),
    .cycles_i    (cycles_i),
    .burst_i     (ctrl_q[CTRL_BURST_BIT]),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_err_i   (mem_rsp_err_i),
    .busy_o      (busy),
    .req_valid_o (mem_req_valid_o),
    .req_write_o (mem_req_write_o),
    .capture_o   (capture),
    .advance_o   (advance),
    .finish_o    (finish),
    .fault_o     (fault),
    .remain_o    (remain_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      fin_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      ctrl_q <= ctrl_i;
      src_q  <= src_addr_i;
      dst_q  <= dst_addr_i;
      fin_q  <= ctrl_i[CTRL_EN_BIT] && (cycles_i == '0);
      err_q  <= 1'b0;
    end else begin
      if (capture) data_q <= mem_rsp_rdata_i;
      if (advance) begin
        src_q <= nxt_addr[0];
        dst_q <= nxt_addr[1];
      end
      if (finish) fin_q <= 1'b1;
      if (fault)  err_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_o               = ctrl_q;
    ctrl_o[CTRL_EN_BIT]  = busy;
    ctrl_o[CTRL_FIN_BIT] = fin_q;
    ctrl_o[CTRL_ERR_BIT] = err_q;
  end

  assign mem_req_addr_o  = mem_req_write_o ? dst_q : src_q;
  assign mem_req_size_o  = width_to_size(ctrl_q[WIDTH_LSB +: 2]);
  assign mem_req_wdata_o = data_q;

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr_i,
  input logic [31:0]      ctrl_o,
  input logic [CNT_W-1:0] remain_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_write_o,
  input logic [AW-1:0]    mem_req_addr_o,
  input logic [1:0]       mem_req_size_o,
  input logic [DW-1:0]    mem_req_wdata_o
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)
       && $stable(mem_req_wdata_o) && $stable(mem_req_size_o)));

  p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_size_o != 2'd3));

  p_remain_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_o[0]) |->
      ((remain_o == $past(remain_o)) || (remain_o == $past(remain_o) - CNT_W'(1))));

  p_finish_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_o[1]) |-> (!ctrl_o[0] && (remain_o == '0) && !mem_req_valid_o));

  p_error_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[4] |-> (!mem_req_valid_o && !ctrl_o[0]));

  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_o[1] && ctrl_o[4]));

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[0] && ctrl_wr_i) |=> ($stable(ctrl_o[21:5]) && $stable(ctrl_o[3:2])));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(
  .AW    (AW),
  .DW    (DW),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/dma_chan_engine_tb_top.sv
`timescale 1ns/1ps
module dma_chan_engine_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 24;
  localparam int LOGN = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_wr = 1'b0;
  logic [31:0]   ctrl_in = '0;
  logic [AW-1:0] src_in = '0, dst_in = '0;
  logic [CW-1:0] cyc_in = '0;
  logic [31:0]   ctrl_o;
  logic [CW-1:0] remain_o;
  logic          mem_req_valid_o, mem_req_write_o;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr_o;
  logic [1:0]    mem_req_size_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic          mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  always #2 clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl_in),
    .src_addr_i(src_in), .dst_addr_i(dst_in), .cycles_i(cyc_in),
    .ctrl_o(ctrl_o), .remain_o(remain_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready),
    .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_size_o(mem_req_size_o), .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_rdata_i(mem_rsp_rdata),
    .mem_rsp_err_i(mem_rsp_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // access log filled by the memory responder
  logic [AW-1:0] lg_addr [LOGN];
  logic          lg_wr   [LOGN];
  logic [DW-1:0] lg_data [LOGN];
  logic [1:0]    lg_size [LOGN];
  logic [CW-1:0] lg_rem  [LOGN];
  int            n_log = 0;
  int            err_at = -1;
  bit            stall_en = 1'b0;
  int            stall_ctr = 0;
  bit            pend = 1'b0, pend_err = 1'b0;
  logic [DW-1:0] pend_data = '0;

  function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  function automatic int stepv(input logic [2:0] c, input bit burst);
    int m;
    case (c)
      3'b001: m = 1;  3'b010: m = 2;  3'b011: m = 4;
      3'b101: m = -1; 3'b110: m = -2; 3'b111: m = -4;
      default: m = 0;
    endcase
    return burst ? m * 4 : m;
  endfunction

  function automatic logic [1:0] exp_size(input logic [1:0] w);
    return (w == 2'b01) ? 2'd1 : (w == 2'b10) ? 2'd0 : 2'd2;
  endfunction

  function automatic logic [31:0] mk(input bit en, input bit burst, input logic [2:0] ss,
                                     input logic [2:0] ds, input logic [1:0] w);
    logic [31:0] c;
    c = '0;
    c[0] = en; c[3] = burst; c[10:8] = ss; c[14:12] = ds; c[21:20] = w;
    return c;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory responder: accepts at most one request, answers at the next negedge
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = pend_data;
        mem_rsp_err   = pend_err;
        pend = 1'b0;
      end
      stall_ctr++;
      mem_req_ready = !stall_en || (stall_ctr % 3 == 0);
      if (rst_n && mem_req_valid_o && mem_req_ready) begin
        if (n_log < LOGN) begin
          lg_addr[n_log] = mem_req_addr_o;
          lg_wr[n_log]   = mem_req_write_o;
          lg_data[n_log] = mem_req_wdata_o;
          lg_size[n_log] = mem_req_size_o;
          lg_rem[n_log]  = remain_o;
        end
        pend      = 1'b1;
        pend_data = mem_req_write_o ? '0 : rd_fn(mem_req_addr_o);
        pend_err  = (n_log == err_at);
        n_log++;
      end
    end
  end

  task automatic prog(input logic [31:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [CW-1:0] n);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_in = c; src_in = s; dst_in = d; cyc_in = n;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (ctrl_o[0] && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic check_log(input string req, input logic [31:0] c, input logic [AW-1:0] s0,
                           input logic [AW-1:0] d0, input int n);
    int beats = c[3] ? 4 : 1;
    logic [AW-1:0] s = s0, d = d0;
    chk(req, "access count", 64'(n_log), 64'(2 * n * beats));
    for (int k = 0; k < n * beats && 2 * k + 1 < n_log; k++) begin
      chk(req, "read kind", 64'(lg_wr[2*k]), 64'(0));
      chk(req, "read addr", 64'(lg_addr[2*k]), 64'(s));
      chk(req, "write kind", 64'(lg_wr[2*k+1]), 64'(1));
      chk(req, "write addr", 64'(lg_addr[2*k+1]), 64'(d));
      chk(req, "write data", 64'(lg_data[2*k+1]), 64'(rd_fn(s)));
      chk("R7", "size", 64'(lg_size[2*k]), 64'(exp_size(c[21:20])));
      chk("R8", "live remain", 64'(lg_rem[2*k+1]), 64'(n - k / beats));
      s = s + 32'(stepv(c[10:8], c[3]));
      d = d + 32'(stepv(c[14:12], c[3]));
    end
  endtask

  task automatic run_ok(input string req, input logic [31:0] c, input logic [AW-1:0] s,
                        input logic [AW-1:0] d, input int n);
    n_log = 0;
    prog(c, s, d, CW'(n));
    wait_idle();
    check_log(req, c, s, d, n);
    chk("R9", "finish bit", 64'(ctrl_o[1]), 64'(1));
    chk("R9", "enable clear", 64'(ctrl_o[0]), 64'(0));
    chk("R9", "remain zero", 64'(remain_o), 64'(0));
    chk("R11", "no error", 64'(ctrl_o[4]), 64'(0));
  endtask

  task automatic t_reset();
    chk("R1", "ctrl_o", 64'(ctrl_o), 64'(0));
    chk("R1", "remain", 64'(remain_o), 64'(0));
    chk("R1", "req valid", 64'(mem_req_valid_o), 64'(0));
  endtask

  task automatic t_single_inc();   // R3 increments, R2 ordering
    run_ok("R3", mk(1, 0, 3'b011, 3'b001, 2'b00), 32'h0000_1000, 32'h0000_2000, 3);
    run_ok("R3", mk(1, 0, 3'b010, 3'b000, 2'b01), 32'h0000_3000, 32'h0000_4000, 2);
  endtask

  task automatic t_burst();        // R6 four beats, step x4
    run_ok("R6", mk(1, 1, 3'b011, 3'b000, 2'b00), 32'h0001_0000, 32'h0002_0000, 2);
    run_ok("R6", mk(1, 1, 3'b110, 3'b001, 2'b10), 32'h0001_0100, 32'h0002_0100, 1);
  endtask

  task automatic t_dec_stall();    // R4 decrements under R2 back-pressure
    stall_en = 1'b1;
    run_ok("R4", mk(1, 0, 3'b111, 3'b101, 2'b10), 32'h0000_5000, 32'h0000_6000, 4);
    run_ok("R2", mk(1, 0, 3'b110, 3'b011, 2'b00), 32'h0000_7000, 32'h0000_8000, 2);
    stall_en = 1'b0;
  endtask

  task automatic t_reserved();     // R5 code 100 fixed, R7 width 11 -> word
    run_ok("R5", mk(1, 0, 3'b100, 3'b001, 2'b01), 32'h0000_9000, 32'h0000_A000, 2);
    run_ok("R5", mk(1, 1, 3'b001, 3'b100, 2'b11), 32'h0000_B000, 32'h0000_C000, 1);
  endtask

  task automatic t_zero();         // R10
    n_log = 0;
    prog(mk(1, 0, 3'b001, 3'b001, 2'b00), 32'h100, 32'h200, '0);
    chk("R10", "finish at once", 64'(ctrl_o[1]), 64'(1));
    chk("R10", "enable clear", 64'(ctrl_o[0]), 64'(0));
    repeat (5) @(negedge clk);
    chk("R10", "no access", 64'(n_log), 64'(0));
  endtask

  task automatic t_err_mid();      // R11 then R12 clear
    n_log = 0;
    err_at = 2;
    prog(mk(1, 0, 3'b001, 3'b001, 2'b00), 32'h300, 32'h400, CW'(3));
    wait_idle();
    repeat (10) @(negedge clk);
    err_at = -1;
    chk("R11", "error bit", 64'(ctrl_o[4]), 64'(1));
    chk("R11", "finish clear", 64'(ctrl_o[1]), 64'(0));
    chk("R11", "remain held", 64'(remain_o), 64'(2));
    chk("R11", "stopped", 64'(n_log), 64'(3));
    prog(mk(0, 0, 3'b001, 3'b001, 2'b00), 32'h500, 32'h600, CW'(7));
    chk("R12", "error cleared", 64'(ctrl_o[4]), 64'(0));
    chk("R12", "not started", 64'(ctrl_o[0]), 64'(0));
    chk("R12", "count loaded", 64'(remain_o), 64'(7));
    repeat (4) @(negedge clk);
    chk("R12", "no access idle", 64'(n_log), 64'(3));
  endtask

  task automatic t_err_last();     // R11 priority over finish
    n_log = 0;
    err_at = 3;
    prog(mk(1, 0, 3'b001, 3'b001, 2'b00), 32'h700, 32'h800, CW'(2));
    wait_idle();
    err_at = -1;
    chk("R11", "last error bit", 64'(ctrl_o[4]), 64'(1));
    chk("R11", "last finish clear", 64'(ctrl_o[1]), 64'(0));
    chk("R11", "last remain", 64'(remain_o), 64'(1));
    chk("R11", "last accesses", 64'(n_log), 64'(4));
  endtask

  task automatic t_busy_ignore();  // R12
    logic [31:0] c = mk(1, 0, 3'b001, 3'b011, 2'b10);
    n_log = 0;
    stall_en = 1'b1;
    prog(c, 32'h0000_D000, 32'h0000_E000, CW'(2));
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_in = mk(1, 1, 3'b111, 3'b111, 2'b00);
    src_in = 32'hFFFF_0000; dst_in = 32'hEEEE_0000; cyc_in = CW'(9);
    @(negedge clk);
    ctrl_wr = 1'b0;
    wait_idle();
    stall_en = 1'b0;
    check_log("R12", c, 32'h0000_D000, 32'h0000_E000, 2);
    chk("R12", "fields kept", 64'(ctrl_o[21:8]), 64'(c[21:8]));
    chk("R12", "finished", 64'(ctrl_o[1]), 64'(1));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_inc();
    t_burst();
    t_dec_stall();
    t_reserved();
    t_zero();
    t_err_mid();
    t_err_last();
    t_busy_ignore();
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule